// File: doc/BRIEF.md
# Four-Phase Almost-Regular Permutation Address Generator

This block produces the read addresses for an almost-regular-permutation interleaver, one address per clock. A start pulse loads a new block length N and four step constants. The generator then walks the index i from 0 to N-1 and presents the permuted position of each index. A valid flag goes with every address, and a last flag marks the final index.

The permuted position is a linear term P0*i plus a phase constant. The phase is chosen by the two low bits of the index. No multiplier or divider is used. A running base is kept reduced modulo N by adding P0 and, when the sum reaches N, taking away N. The four phase constants are reduced once per block when start is seen, and each is then held for the whole block. A single add and compare-and-subtract step therefore gives every address. That step sits in front of one output register.

Top module: `arp_addr_gen`

## Requirements
- R1: While rst_n is low, and afterwards until the first start, addr_valid_o, addr_last_o and addr_o are all 0.
- R2: If start_i is sampled high at rising edge k, the address for index i is presented after edge k+1+i. addr_valid_o then stays high for exactly N consecutive cycles and drops afterwards unless another start is sampled.
- R3: With phase = i[1:0], the address is (P0*i + 1) mod N for phase 0, (P0*i + 1 + N/2 + P1) mod N for phase 1, (P0*i + 1 + P2) mod N for phase 2 and (P0*i + 1 + N/2 + P3) mod N for phase 3.
- R4: Every address presented with addr_valid_o high is below N.
- R5: addr_last_o is high only together with addr_valid_o, and only for index N-1.
- R6: A start sampled while a block is running abandons that block. The address of index 0 of the new block follows one cycle later with no idle cycle, and uses the newly sampled parameters.
- R7: blk_len_i, step_i and ofs1_i..ofs3_i are sampled only on a cycle with start_i high. Changing them on any other cycle does not alter the addresses of the running block.
- R8: Operating range: N is even with 4 <= N <= 2^AW-2, and P0, P1, P2 and P3 are each below N. R3 holds at both ends of this range, including N=4 and the largest N with every step constant equal to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Begin a new block; samples the parameters below |
| blk_len_i | input | AW | Block length N |
| step_i | input | AW | Linear step P0 |
| ofs1_i | input | AW | Phase-1 constant P1 |
| ofs2_i | input | AW | Phase-2 constant P2 |
| ofs3_i | input | AW | Phase-3 constant P3 |
| addr_valid_o | output | 1 | Address on addr_o is valid |
| addr_o | output | AW | Interleaved address |
| addr_last_o | output | 1 | Address belongs to index N-1 |

## Verification
Some properties are checked on every cycle. Each reduced phase constant stays below N while a block runs. Each presented address is in range. The last flag never appears without valid. A start always resets the index and base to zero. The sampled length and step hold steady between starts. The run stops after index N-1. The formula values themselves, the one-cycle latency, seamless restart and the insensitivity to parameter changes mid-block can only be shown by the bench. The bench compares every address against a product-based reference across several lengths and constant sets.

// File: rtl/arp_pkg.sv
package arp_pkg;
  // number of offset phases selected by the low index bits
  localparam int unsigned ARP_PHASES = 4;
  localparam int unsigned ARP_PH_W   = $clog2(ARP_PHASES);
endpackage

// File: rtl/arp_modadd.sv
// (a + b) mod n for a, b < n: one adder and one compare-and-subtract.
module arp_modadd #(
  parameter int unsigned AW = 13
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic [AW-1:0] n_i,
  output logic [AW-1:0] y_o
);
  logic [AW:0] sum;
  logic [AW:0] red;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    red = sum - {1'b0, n_i};
    y_o = (sum >= {1'b0, n_i}) ? red[AW-1:0] : sum[AW-1:0];
  end
endmodule

// File: rtl/arp_offset_table.sv
// Reduces the four phase constants (including the +1) once per block.
module arp_offset_table
  import arp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            run_i,
  input  logic [AW-1:0]                   n_run_i,
  input  logic [AW-1:0]                   blk_len_i,
  input  logic [AW-1:0]                   ofs1_i,
  input  logic [AW-1:0]                   ofs2_i,
  input  logic [AW-1:0]                   ofs3_i,
  output logic [ARP_PHASES-1:0][AW-1:0]   ofs_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [ARP_PHASES-1:0][AW-1:0] raw;
  logic [ARP_PHASES-1:0][AW-1:0] ofs_d;
  logic [ARP_PHASES-1:0][AW-1:0] ofs_q;
  logic [AW-1:0]                 half;

  assign half   = blk_len_i >> 1;
  assign raw[0] = '0;
  assign raw[1] = ofs1_i;
  assign raw[2] = ofs2_i;
  assign raw[3] = ofs3_i;

  for (genvar k = 0; k < ARP_PHASES; k++) begin : g_phase
    logic [AW-1:0] lead;
    logic [AW-1:0] part;
    if ((k % 2) == 1) begin : g_odd
      assign lead = half;
    end else begin : g_even
      assign lead = '0;
    end
    arp_modadd #(.AW(AW)) u_part (
      .a_i(lead), .b_i(raw[k]), .n_i(blk_len_i), .y_o(part)
    );
    arp_modadd #(.AW(AW)) u_inc (
      .a_i(part), .b_i(ONE), .n_i(blk_len_i), .y_o(ofs_d[k])
    );

    AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (ofs_q[k] < n_run_i)); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (start_i) begin
      ofs_q <= ofs_d;
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/arp_base_walk.sv
// Index counter and running base (P0*i) mod N; holds the block config.
module arp_base_walk #(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] blk_len_i,
  input  logic [AW-1:0] step_i,
  output logic          run_o,
  output logic          is_last_o,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] n_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          run_q,  run_d;
  logic [AW-1:0] idx_q,  idx_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] n_q,    n_d;
  logic [AW-1:0] p0_q,   p0_d;
  logic [AW-1:0] base_nx;
  logic          at_end;
  logic          cfg_en;
  logic          walk_en;

  arp_modadd #(.AW(AW)) u_step (
    .a_i(base_q), .b_i(p0_q), .n_i(n_q), .y_o(base_nx)
  );

  assign at_end  = (idx_q == (n_q - ONE));
  assign cfg_en  = start_i;
  assign walk_en = start_i | run_q;

  always_comb begin
    n_d    = n_q;
    p0_d   = p0_q;
    run_d  = run_q;
    idx_d  = idx_q;
    base_d = base_q;
    if (start_i) begin
      n_d    = blk_len_i;
      p0_d   = step_i;
      run_d  = 1'b1;
      idx_d  = '0;
      base_d = '0;
    end else if (run_q) begin
      if (at_end) begin
        run_d = 1'b0;
      end else begin
        idx_d  = idx_q + ONE;
        base_d = base_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= '0;
      p0_q <= '0;
    end else if (cfg_en) begin
      n_q  <= n_d;
      p0_q <= p0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (walk_en) begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      base_q <= base_d;
    end
  end

  assign run_o     = run_q;
  assign is_last_o = run_q & at_end;
  assign idx_o     = idx_q;
  assign base_o    = base_q;
  assign n_o       = n_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (idx_q < n_q && base_q < n_q)); // R4
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_end && !start_i) |=> !run_q); // R5
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && idx_q == '0 && base_q == '0)); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(n_q) && $stable(p0_q))); // R7
endmodule

// File: rtl/arp_addr_out.sv
// Adds the phase constant to the base and registers the result.
module arp_addr_out
  import arp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_i,
  input  logic                          is_last_i,
  input  logic [AW-1:0]                 idx_i,
  input  logic [AW-1:0]                 base_i,
  input  logic [AW-1:0]                 n_i,
  input  logic [ARP_PHASES-1:0][AW-1:0] ofs_i,
  output logic                          valid_o,
  output logic [AW-1:0]                 addr_o,
  output logic                          last_o
);
  logic [ARP_PH_W-1:0] phase;
  logic [AW-1:0]       sel_ofs;
  logic [AW-1:0]       addr_d;
  logic                valid_q, last_q;
  logic [AW-1:0]       addr_q;

  assign phase   = idx_i[ARP_PH_W-1:0];
  assign sel_ofs = ofs_i[phase];

  arp_modadd #(.AW(AW)) u_sum (
    .a_i(base_i), .b_i(sel_ofs), .n_i(n_i), .y_o(addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= run_i;
      last_q  <= is_last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (run_i) begin
      addr_q <= addr_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign last_o  = last_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (addr_q < $past(n_i))); // R4
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> valid_q); // R5
endmodule

// File: rtl/arp_addr_gen.sv
module arp_addr_gen
  import arp_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] blk_len_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] ofs1_i,
  input  logic [AW-1:0] ofs2_i,
  input  logic [AW-1:0] ofs3_i,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_last_o
);
  logic                          run;
  logic                          is_last;
  logic [AW-1:0]                 idx;
  logic [AW-1:0]                 base;
  logic [AW-1:0]                 n_run;
  logic [ARP_PHASES-1:0][AW-1:0] ofs;

  arp_base_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .blk_len_i(blk_len_i), .step_i(step_i),
    .run_o(run), .is_last_o(is_last), .idx_o(idx),
    .base_o(base), .n_o(n_run)
  );

  arp_offset_table #(.AW(AW)) u_ofs (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run),
    .n_run_i(n_run), .blk_len_i(blk_len_i),
    .ofs1_i(ofs1_i), .ofs2_i(ofs2_i), .ofs3_i(ofs3_i),
    .ofs_o(ofs)
  );

  arp_addr_out #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .run_i(run), .is_last_i(is_last),
    .idx_i(idx), .base_i(base), .n_i(n_run), .ofs_i(ofs),
    .valid_o(addr_valid_o), .addr_o(addr_o), .last_o(addr_last_o)
  );
endmodule

// File: tb/sim_arp_addr_gen.sv
`timescale 1ns/1ps
module sim_arp_addr_gen;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] blk_len_i, step_i, ofs1_i, ofs2_i, ofs3_i;
  logic          addr_valid_o;
  logic [AW-1:0] addr_o;
  logic          addr_last_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  arp_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .blk_len_i(blk_len_i), .step_i(step_i),
    .ofs1_i(ofs1_i), .ofs2_i(ofs2_i), .ofs3_i(ofs3_i),
    .addr_valid_o(addr_valid_o), .addr_o(addr_o), .addr_last_o(addr_last_o)
  );

  // columns: N, P0, P1, P2, P3, scramble-after-start
  localparam int TBL [0:5][0:5] = '{
    '{24,   5,    3,    7,    11,   0},
    '{48,   13,   0,    24,   47,   1},
    '{40,   19,   39,   39,   39,   0},
    '{4,    1,    0,    0,    0,    1},
    '{8190, 8189, 8189, 8189, 8189, 0},
    '{100,  0,    50,   99,   1,    1}
  };

  function automatic int ref_addr(int n, int p0, int p1, int p2, int p3, int i);
    longint s;
    s = longint'(p0) * i + 1;
    case (i % 4)
      1: s += n / 2 + p1;
      2: s += p2;
      3: s += n / 2 + p3;
      default: ;
    endcase
    return int'(s % n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drives start for one edge; returns at the negedge after the sampling edge
  task automatic kick(input int n, p0, p1, p2, p3, input bit scramble);
    @(negedge clk);
    start_i = 1'b1; blk_len_i = AW'(n); step_i = AW'(p0);
    ofs1_i = AW'(p1); ofs2_i = AW'(p2); ofs3_i = AW'(p3);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (scramble) begin // R7: junk on parameter inputs mid-block
      blk_len_i = AW'(6); step_i = AW'(5); ofs1_i = AW'(4);
      ofs2_i = AW'(3); ofs3_i = AW'(2);
    end
  endtask

  task automatic walk(input int n, p0, p1, p2, p3, input int count, input bit tail);
    for (int i = 0; i < count; i++) begin
      int e;
      @(negedge clk);
      e = ref_addr(n, p0, p1, p2, p3, i);
      chk(addr_valid_o === 1'b1, "R2 valid", int'(addr_valid_o), 1);
      chk(addr_o === AW'(e), "R3 address", int'(addr_o), e);
      chk(int'(addr_o) < n, "R4 range", int'(addr_o), n);
      chk(addr_last_o === (i == n - 1), "R5 last", int'(addr_last_o), int'(i == n - 1));
    end
    if (tail) begin
      @(negedge clk);
      chk(addr_valid_o === 1'b0, "R2 valid drops", int'(addr_valid_o), 0);
      chk(addr_last_o === 1'b0, "R5 last clear", int'(addr_last_o), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    blk_len_i = '0; step_i = '0; ofs1_i = '0; ofs2_i = '0; ofs3_i = '0;
    repeat (3) @(negedge clk);
    chk(addr_valid_o === 1'b0, "R1 valid in reset", int'(addr_valid_o), 0);
    chk(addr_last_o === 1'b0, "R1 last in reset", int'(addr_last_o), 0);
    chk(addr_o === '0, "R1 addr in reset", int'(addr_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr_valid_o === 1'b0, "R1 idle after reset", int'(addr_valid_o), 0);

    // table walk: R2..R5, R7 (scramble column), R8 (rows 4 and 5)
    for (int r = 0; r < 6; r++) begin
      kick(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][5] != 0);
      walk(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][0], 1'b1);
    end

    // R6: restart mid-block with new parameters, no idle cycle
    kick(60, 7, 2, 9, 30, 1'b0);
    walk(60, 7, 2, 9, 30, 10, 1'b0);
    kick(36, 11, 5, 17, 35, 1'b0);
    chk(addr_valid_o === 1'b1, "R6 no gap at restart", int'(addr_valid_o), 1);
    walk(36, 11, 5, 17, 35, 36, 1'b1);

    // R6: restart exactly on the last index of a block
    kick(8, 3, 1, 2, 7, 1'b0);
    walk(8, 3, 1, 2, 7, 6, 1'b0);
    kick(12, 5, 6, 11, 0, 1'b0);
    walk(12, 5, 6, 11, 0, 12, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule